// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Engine

This block is a single copy channel that moves blocks of memory without processor involvement. Software places a list of descriptors in memory, each naming a source, a destination and a byte length, and each pointing at the next one. It programs the address of the first descriptor into the engine, clears any stale status, and sets the enable and start bits together. The engine then reads each descriptor, copies the data one 32-bit word at a time, and follows the next pointer until it reads a null pointer.

Software observes progress by polling. A status bit reads as one for as long as the chain is in flight. Sticky flags record descriptor completion, chain completion, a malformed descriptor and a failed memory access. Each sticky flag is cleared by writing a one to it. The engine reaches memory through one request/response port with a single access outstanding, and software reaches it through a small 32-bit register port.

Top module: `chain_copy_dma`

## Requirements
- R1: A register write to offset 0x00 with bit 0 (enable) and bit 1 (start) both set, made while the channel is idle, loads the first-descriptor address held at offset 0x10. The write makes status bit 10 (active) read 1 from the following cycle until the channel stops. Offset 0x00 reads back the enable bit in bit 0; start always reads 0.
- R2: A descriptor is eight 32-bit words at its base address. The engine reads the first six words in ascending order: +0x00 next pointer, +0x04 source address, +0x08 upper source address, +0x0C destination address, +0x10 byte count, +0x14 control. The last two words are never read.
- R3: For a descriptor with byte count N, the engine copies the N/4 words from the source to the destination in ascending address order. N = 0 copies nothing, and the word after the copied range is not written.
- R4: After a descriptor completes, a nonzero next pointer makes the engine fetch the descriptor at that address. A zero next pointer ends the chain: status bit 8 is set and bit 10 clears.
- R5: Status bit 9 is set whenever any descriptor's copy completes.
- R6: A descriptor is malformed if its upper source address is nonzero, its byte count is not a multiple of 4, or its control bit 6 (local-to-local copy) is clear. A malformed descriptor sets status bit 5 and copies nothing. It ends the chain without setting bits 8 or 9 for itself.
- R7: An error response on the memory port sets status bit 1 and ends the chain at once. No further access is issued, and a write whose read failed does not happen. The failure mask for software is 0x2E.
- R8: Status bits 1, 5, 8 and 9 are cleared by writing 1 to them, and a written 0 leaves them unchanged. Bits 2 and 3 are accepted in the clear mask but always read 0. All status and control bits are 0 after reset.
- R9: Writes to offset 0x10 while status bit 10 is set are ignored.
- R10: Clearing the enable bit while a chain runs lets the pending access finish, together with the write that belongs to an already-read word. No further access is issued, bit 10 clears, and bits 8 and 9 are not set by the stop.
- R11: The memory request stays asserted, with a stable address and direction, until it is acknowledged.
- R12: A start written while the channel is active, or written without the enable bit, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete, one cycle |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The in-RTL assertions check on every cycle that a request is held stable until its acknowledge, and that the completion and error events exclude one another. They also check that chain end, descriptor faults and a stop at a word boundary all leave the channel idle on the next cycle, that base-address writes are locked out while active, and that write-one-to-clear and write-zero-keep behave as required. Whether the right words land at the right addresses, in which order descriptors are walked, and how much of a copy survives a mid-chain disable can only be shown by the bench's scenarios. These scenarios sweep copy lengths, build multi-descriptor chains, inject faults at chosen addresses and compare memory contents against arithmetic expectations.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  localparam int AW         = 32;
  localparam int DW         = 32;
  localparam int WB         = DW / 8;
  localparam int DESC_WORDS = 6;

  localparam int REG_CTL  = 'h00;
  localparam int REG_STAT = 'h04;
  localparam int REG_BASE = 'h10;

  localparam int CTL_EN    = 0;
  localparam int CTL_GO    = 1;
  localparam int ST_MERR   = 1;
  localparam int ST_RSV2   = 2;
  localparam int ST_RSV3   = 3;
  localparam int ST_DERR   = 5;
  localparam int ST_CHAIN  = 8;
  localparam int ST_DESC   = 9;
  localparam int ST_ACTIVE = 10;
  localparam int DC_LOCAL  = 6;

  typedef enum logic [1:0] {
    W_IDLE,
    W_FETCH,
    W_READ,
    W_WRITE
  } walk_t;

  // byte address of word idx inside a descriptor
  function automatic logic [AW-1:0] desc_word_addr(input logic [AW-1:0] base,
                                                   input logic [2:0]    idx);
    return base + {{(AW-5){1'b0}}, idx, 2'b00};
  endfunction

  // descriptor the engine refuses to run
  function automatic logic desc_bad(input logic [AW-1:0] src_hi,
                                    input logic [AW-1:0] count,
                                    input logic [DW-1:0] ctl);
    return (src_hi != '0) || (count[1:0] != 2'b00) || !ctl[DC_LOCAL];
  endfunction

  // true when the word at byte offset off is the final one of count bytes
  function automatic logic last_word(input logic [AW-1:0] off,
                                     input logic [AW-1:0] count);
    return (off + AW'(WB)) == count;
  endfunction

endpackage

// File: rtl/ccd_regs.sv
module ccd_regs
  import ccd_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            busy,
  input  logic            ev_desc_end,
  input  logic            ev_chain_end,
  input  logic            ev_desc_err,
  input  logic            ev_mem_err,
  output logic            launch,
  output logic [AW-1:0]   start_addr,
  output logic            enable
);

  logic ctl_wr, stat_wr, base_wr;
  logic st_merr, st_derr, st_chain, st_desc;
  logic [AW-1:0] base_q;

  assign ctl_wr  = reg_wr && (reg_addr == RA_W'(REG_CTL));
  assign stat_wr = reg_wr && (reg_addr == RA_W'(REG_STAT));
  assign base_wr = reg_wr && (reg_addr == RA_W'(REG_BASE));

  assign launch     = ctl_wr && reg_wdata[CTL_EN] && reg_wdata[CTL_GO] && !busy;
  assign start_addr = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      base_q   <= '0;
      st_merr  <= 1'b0;
      st_derr  <= 1'b0;
      st_chain <= 1'b0;
      st_desc  <= 1'b0;
    end else begin
      if (ctl_wr) enable <= reg_wdata[CTL_EN];
      if (base_wr && !busy) base_q <= reg_wdata;
      st_merr  <= (st_merr  && !(stat_wr && reg_wdata[ST_MERR]))  || ev_mem_err;
      st_derr  <= (st_derr  && !(stat_wr && reg_wdata[ST_DERR]))  || ev_desc_err;
      st_chain <= (st_chain && !(stat_wr && reg_wdata[ST_CHAIN])) || ev_chain_end;
      st_desc  <= (st_desc  && !(stat_wr && reg_wdata[ST_DESC]))  || ev_desc_end;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(REG_CTL)) begin
      reg_rdata[CTL_EN] = enable;
    end else if (reg_addr == RA_W'(REG_STAT)) begin
      reg_rdata[ST_MERR]   = st_merr;
      reg_rdata[ST_RSV2]   = 1'b0;
      reg_rdata[ST_RSV3]   = 1'b0;
      reg_rdata[ST_DERR]   = st_derr;
      reg_rdata[ST_CHAIN]  = st_chain;
      reg_rdata[ST_DESC]   = st_desc;
      reg_rdata[ST_ACTIVE] = busy;
    end else if (reg_addr == RA_W'(REG_BASE)) begin
      reg_rdata = base_q;
    end
  end

  // R9: base register locked while the chain runs
  assert_base_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && base_wr) |=> $stable(base_q));

  // R8: a written one clears a descriptor-done flag unless a new one arrives
  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[ST_DESC] && !ev_desc_end) |=> !st_desc);

  // R8: a written zero keeps the chain-done flag
  assert_w0_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !reg_wdata[ST_CHAIN] && st_chain) |=> st_chain);

endmodule

// File: rtl/ccd_walker.sv
module ccd_walker
  import ccd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] start_addr,
  input  logic          enable,
  output logic          busy,
  output logic          ev_desc_end,
  output logic          ev_chain_end,
  output logic          ev_desc_err,
  output logic          ev_mem_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata
);

  localparam logic [2:0] DESC_LAST = 3'(DESC_WORDS - 1);

  walk_t         st;
  logic [2:0]    widx;
  logic [AW-1:0] cur, nxt, src, src_hi, dst, cnt, off;
  logic [DW-1:0] hold;

  logic ack_ok, fetch_last, fin_empty, fin_copy, advance;

  assign busy    = (st != W_IDLE);
  assign mem_req = busy;
  assign mem_we  = (st == W_WRITE);
  assign mem_wdata = hold;

  always_comb begin
    case (st)
      W_FETCH: mem_addr = desc_word_addr(cur, widx);
      W_READ:  mem_addr = src + off;
      W_WRITE: mem_addr = dst + off;
      default: mem_addr = cur;
    endcase
  end

  assign ack_ok      = mem_ack && !mem_err;
  assign fetch_last  = (st == W_FETCH) && ack_ok && (widx == DESC_LAST);
  assign ev_desc_err = fetch_last && desc_bad(src_hi, cnt, mem_rdata);
  assign fin_empty   = fetch_last && !ev_desc_err && (cnt == '0);
  assign fin_copy    = (st == W_WRITE) && ack_ok && last_word(off, cnt);
  assign ev_desc_end = fin_empty || fin_copy;
  assign ev_chain_end = ev_desc_end && (nxt == '0);
  assign ev_mem_err  = busy && mem_ack && mem_err;
  assign advance     = (nxt != '0) && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      widx   <= '0;
      cur    <= '0;
      nxt    <= '0;
      src    <= '0;
      src_hi <= '0;
      dst    <= '0;
      cnt    <= '0;
      off    <= '0;
      hold   <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (launch) begin
            cur  <= start_addr;
            widx <= '0;
            st   <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (mem_ack) begin
            if (mem_err) begin
              st <= W_IDLE;
            end else begin
              case (widx)
                3'd0:    nxt    <= mem_rdata;
                3'd1:    src    <= mem_rdata;
                3'd2:    src_hi <= mem_rdata;
                3'd3:    dst    <= mem_rdata;
                3'd4:    cnt    <= mem_rdata;
                default: ;
              endcase
              if (widx == DESC_LAST) begin
                if (ev_desc_err) begin
                  st <= W_IDLE;
                end else if (cnt == '0) begin
                  if (advance) begin
                    cur  <= nxt;
                    widx <= '0;
                  end else begin
                    st <= W_IDLE;
                  end
                end else if (!enable) begin
                  st <= W_IDLE;
                end else begin
                  off <= '0;
                  st  <= W_READ;
                end
              end else if (!enable) begin
                st <= W_IDLE;
              end else begin
                widx <= widx + 3'd1;
              end
            end
          end
        end
        W_READ: begin
          if (mem_ack) begin
            if (mem_err) begin
              st <= W_IDLE;
            end else begin
              hold <= mem_rdata;
              st   <= W_WRITE;
            end
          end
        end
        W_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              st <= W_IDLE;
            end else if (last_word(off, cnt)) begin
              if (advance) begin
                cur  <= nxt;
                widx <= '0;
                st   <= W_FETCH;
              end else begin
                st <= W_IDLE;
              end
            end else begin
              off <= off + AW'(WB);
              st  <= enable ? W_READ : W_IDLE;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R11: a request is held with the same address and direction until acked
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4 R6 R7: at most one outcome per cycle
  assert_event_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_desc_end, ev_desc_err, ev_mem_err}));

  // R4: chain end returns to idle
  assert_chain_end_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_end |=> !busy);

  // R6: malformed descriptor aborts
  assert_fault_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_err |=> !busy);

  // R7: memory error aborts
  assert_mem_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_err |=> !busy);

  // R10: with enable low, an acked access other than a read ends activity
  assert_stop_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && !enable && (st != W_READ)) |=> !busy);

  // R1: a launch accepted from idle makes the channel active
  assert_launch_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy);

endmodule

// File: rtl/chain_copy_dma.sv
module chain_copy_dma
  import ccd_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata
);

  logic          busy, launch, enable;
  logic          ev_desc_end, ev_chain_end, ev_desc_err, ev_mem_err;
  logic [AW-1:0] start_addr;

  ccd_regs #(.RA_W(RA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .busy         (busy),
    .ev_desc_end  (ev_desc_end),
    .ev_chain_end (ev_chain_end),
    .ev_desc_err  (ev_desc_err),
    .ev_mem_err   (ev_mem_err),
    .launch       (launch),
    .start_addr   (start_addr),
    .enable       (enable)
  );

  ccd_walker u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .start_addr   (start_addr),
    .enable       (enable),
    .busy         (busy),
    .ev_desc_end  (ev_desc_end),
    .ev_chain_end (ev_chain_end),
    .ev_desc_err  (ev_desc_err),
    .ev_mem_err   (ev_mem_err),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .mem_rdata    (mem_rdata)
  );

endmodule

// File: tb/chain_copy_dma_bench.sv
module chain_copy_dma_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RA_W       = 5;
  localparam int MEM_WORDS  = 2048;
  localparam logic [31:0] SENT    = 32'hDEADBEEF;
  localparam logic [31:0] DST_LO  = 32'h1800;
  localparam logic [31:0] ALL_CLR = 32'h0000032E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            reg_wr = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            mem_req, mem_we;
  logic [31:0]     mem_addr, mem_wdata;
  logic            mem_ack, mem_err;
  logic [31:0]     mem_rdata;

  logic [31:0] mem [MEM_WORDS];
  logic        err_on = 1'b0;
  logic [31:0] err_addr = '0;
  int          hold_viol = 0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  chain_copy_dma #(.RA_W(RA_W)) u_chain_copy_dma (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledge one cycle after accepting a request
  initial begin
    logic [31:0] seen_addr;
    logic        seen_we;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    seen_addr = '0; seen_we = 1'b0;
    forever begin
      @(posedge clk);
      if (mem_ack) begin
        mem_ack <= 1'b0;
      end else if (mem_req) begin
        // R11: model-side view of request stability since acceptance
        if (seen_we !== mem_we && seen_addr === mem_addr) hold_viol++;
        seen_addr = mem_addr;
        seen_we   = mem_we;
        if (mem_we && !(err_on && mem_addr == err_addr)) mem[mem_addr[12:2]] = mem_wdata;
        mem_rdata <= mem[mem_addr[12:2]];
        mem_err   <= err_on && (mem_addr == err_addr);
        mem_ack   <= 1'b1;
      end
    end
  end

  // R11: request must not move between acceptance and acknowledge
  initial begin
    logic [31:0] a_prev;
    logic        pend;
    pend = 1'b0; a_prev = '0;
    forever begin
      @(negedge clk);
      if (pend && mem_ack && (mem_addr !== a_prev)) hold_viol++;
      pend   = mem_req && !mem_ack;
      a_prev = mem_addr;
    end
  end

  function automatic logic [31:0] pat(input int i);
    logic [15:0] v;
    v = i[15:0];
    return {v, ~v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rw(input logic [RA_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rr(input logic [RA_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = pat(i);
    for (int i = int'(DST_LO >> 2); i < MEM_WORDS; i++) mem[i] = SENT;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] sl,
                          input logic [31:0] sh, input logic [31:0] d, input logic [31:0] c,
                          input logic [31:0] ct);
    int b;
    b = int'(a >> 2);
    mem[b]   = nx; mem[b+1] = sl; mem[b+2] = sh; mem[b+3] = d;
    mem[b+4] = c;  mem[b+5] = ct; mem[b+6] = 32'h0; mem[b+7] = 32'h0;
  endtask

  task automatic go(input logic [31:0] base);
    rw(5'h04, ALL_CLR);
    rw(5'h10, base);
    rw(5'h00, 32'h3);
  endtask

  task automatic wait_idle(output logic [31:0] s);
    int n;
    n = 0;
    do begin
      rr(5'h04, s);
      n++;
    end while (s[10] && n < 20000);
  endtask

  task automatic chk_copy(input string tag, input logic [31:0] s, input logic [31:0] d, input int nw);
    for (int j = 0; j < nw; j++) chk(tag, mem[int'(d >> 2) + j], pat(int'(s >> 2) + j));
    chk(tag, mem[int'(d >> 2) + nw], SENT);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, r;
    int k;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    rr(5'h04, r); chk("R8 reset status", r, 32'h0);
    rr(5'h00, r); chk("R8 reset control", r, 32'h0);
    rr(5'h10, r); chk("R8 reset base", r, 32'h0);

    // R2 R3 R4 length sweep, single descriptor
    for (int n = 0; n <= 8; n++) begin
      logic [31:0] sa, da, dsc;
      fill();
      sa  = 32'h1000 + 32'(n * 4);
      da  = DST_LO + 32'(n * 8);
      dsc = 32'h100 + 32'(n * 32);
      put_desc(dsc, 32'h0, sa, 32'h0, da, 32'(n * 4), 32'h40);
      go(dsc);
      rr(5'h10, r); chk("R1 base readback", r, dsc);
      wait_idle(s);
      chk("R4 single status", s, 32'h300);
      chk_copy("R3 copy sweep", sa, da, n);
    end

    // R4 three-descriptor chain at scattered addresses
    fill();
    put_desc(32'h200, 32'h140, 32'h1100, 32'h0, 32'h1800, 32'd32, 32'h40);
    put_desc(32'h140, 32'h3E0, 32'h1040, 32'h0, 32'h1900, 32'd48, 32'h40);
    put_desc(32'h3E0, 32'h0,   32'h1200, 32'h0, 32'h1A00, 32'd16, 32'h40);
    go(32'h200);
    wait_idle(s);
    chk("R4 chain status", s, 32'h300);
    chk_copy("R4 chain first", 32'h1100, 32'h1800, 8);
    chk_copy("R4 chain second", 32'h1040, 32'h1900, 12);
    chk_copy("R4 chain third", 32'h1200, 32'h1A00, 4);

    // R5 R6 good descriptor then malformed one
    fill();
    put_desc(32'h100, 32'h180, 32'h1000, 32'h0, 32'h1800, 32'd8, 32'h40);
    put_desc(32'h180, 32'h0,   32'h1080, 32'h0, 32'h1900, 32'd8, 32'h00);
    go(32'h100);
    wait_idle(s);
    chk("R5 per-descriptor flag then fault", s, 32'h220);
    chk_copy("R5 first copied", 32'h1000, 32'h1800, 2);
    chk("R6 faulty not copied", mem[32'h1900 >> 2], SENT);

    // R6 each malformed kind
    for (int f = 0; f < 3; f++) begin
      fill();
      put_desc(32'h100, 32'h0, 32'h1000, (f == 0) ? 32'h1 : 32'h0, 32'h1800,
               (f == 1) ? 32'd6 : 32'd8, (f == 2) ? 32'h0 : 32'h40);
      go(32'h100);
      wait_idle(s);
      chk("R6 fault status", s, 32'h020);
      chk("R6 fault no write", mem[32'h1800 >> 2], SENT);
    end

    // R7 error response on the third source word
    fill();
    put_desc(32'h100, 32'h0, 32'h1000, 32'h0, 32'h1800, 32'd64, 32'h40);
    err_on = 1'b1; err_addr = 32'h1008;
    go(32'h100);
    wait_idle(s);
    err_on = 1'b0;
    chk("R7 error status", s, 32'h002);
    chk_copy("R7 prefix then stop", 32'h1000, 32'h1800, 2);

    // R8 write-one-to-clear
    rw(5'h04, 32'h0);   rr(5'h04, r); chk("R8 zero keeps", r, 32'h002);
    rw(5'h04, 32'h02C); rr(5'h04, r); chk("R8 other ones keep", r, 32'h002);
    rw(5'h04, 32'h002); rr(5'h04, r); chk("R8 one clears", r, 32'h0);
    fill();
    put_desc(32'h100, 32'h0, 32'h1000, 32'h0, 32'h1800, 32'd4, 32'h40);
    go(32'h100);
    wait_idle(s);
    rw(5'h04, 32'h100); rr(5'h04, r); chk("R8 clear chain flag only", r, 32'h200);
    rw(5'h04, 32'h200); rr(5'h04, r); chk("R8 clear desc flag", r, 32'h0);

    // R1 R9 R12 long copy with writes while active
    fill();
    put_desc(32'h100, 32'h0, 32'h1000, 32'h0, 32'h1800, 32'd256, 32'h40);
    go(32'h100);
    rr(5'h04, r); chk("R1 active bit", r & 32'h400, 32'h400);
    rr(5'h00, r); chk("R1 enable readback", r, 32'h1);
    rw(5'h10, 32'h3C0);
    rr(5'h10, r); chk("R9 base locked", r, 32'h100);
    rw(5'h00, 32'h3);
    wait_idle(s);
    chk("R12 restart ignored status", s, 32'h300);
    chk_copy("R12 restart ignored copy", 32'h1000, 32'h1800, 64);

    // R12 start without enable
    fill();
    put_desc(32'h100, 32'h0, 32'h1000, 32'h0, 32'h1800, 32'd16, 32'h40);
    rw(5'h04, ALL_CLR);
    rw(5'h10, 32'h100);
    rw(5'h00, 32'h2);
    repeat (20) @(negedge clk);
    rr(5'h04, r); chk("R12 no launch status", r, 32'h0);
    chk("R12 no launch memory", mem[32'h1800 >> 2], SENT);

    // R10 disable mid-copy
    fill();
    put_desc(32'h100, 32'h0, 32'h1000, 32'h0, 32'h1800, 32'd256, 32'h40);
    go(32'h100);
    repeat (60) @(negedge clk);
    rw(5'h00, 32'h0);
    wait_idle(s);
    chk("R10 stopped status", s, 32'h0);
    k = 0;
    while (k < 64 && mem[(32'h1800 >> 2) + k] !== SENT) k++;
    chk("R10 partial length", 32'((k > 0) && (k < 64)), 32'h1);
    for (int j = 0; j < k; j++) chk("R10 prefix data", mem[(32'h1800 >> 2) + j], pat((32'h1000 >> 2) + j));
    for (int j = k; j < 64; j++) chk("R10 untouched tail", mem[(32'h1800 >> 2) + j], SENT);

    chk("R11 request hold", 32'(hold_viol), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule